// File: doc/BRIEF.md
# Backlight PWM Generator with Prescaled Period and Duty

This block turns a slow reference tick into one pulse-width-modulated output, typically used to dim a display backlight. Both the period and the on-time are counted in multiples of a programmable prescale factor. Each has one extra reference tick on top. The block sees only a one-cycle clock-enable pulse at the reference rate, and it advances its counters only on those pulses. The rate of that pulse is picked elsewhere from a 3-bit frequency code.

Software-facing values arrive as plain register outputs: an 8-bit prescale, a 16-bit period scale, a 16-bit duty value and a control byte. The block copies the prescale, scale and duty into private shadow registers at a period boundary. It also copies them at the tick where the output is switched on from the off state. Register writes that land part-way through a period therefore never show up as a broken cycle. While the generator is off, the output rests at the full-brightness level.

Top module: `bl_pwm_gen`

## Requirements
- R1: With prescale P (P ≥ 1) and scale S, one output period lasts exactly P·S+1 reference ticks, and the waveform repeats with that length.
- R2: With duty D < S, the output is at the active level for the first P·D+1 ticks of each period and at the inactive level for the remaining ticks.
- R3: With duty D ≥ S, the output stays at the active level for the whole period.
- R4: A prescale value of 0 behaves exactly like a prescale value of 1.
- R5: Control bit 1 is the enable. While it is 0, the output is 1 (full brightness) whatever control bit 0 holds. Control bits 7..2 have no effect.
- R6: Control bit 0 is the invert. While enabled, the active level is 1 when the bit is 0 and 0 when the bit is 1.
- R7: Prescale, scale or duty values changed part-way through a period do not alter that period; they apply from the next period. A tick that finds the enable set after it was clear begins a new period at tick position 0, using the register values present at that tick.
- R8: The output is registered and changes only in the cycle after a reference tick; without a tick it holds its value.
- R9: After reset the generator is disabled and the output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable pulse at the reference rate |
| cfg_prediv | input | 8 | Prescale factor register value (0 treated as 1) |
| cfg_scale | input | 16 | Period scale register value |
| cfg_duty | input | 16 | Duty value register |
| cfg_ctrl | input | 8 | Control byte: bit 1 enable, bit 0 invert |
| pwm_o | output | 1 | Registered PWM output |

## Verification
On every cycle, the assertions check four things. The output holds between reference ticks. A disabled tick drives the output to 1. A tick that switches the generator on starts at the active level. The inner and outer counters stay inside the limits set by the shadowed prescale and scale. Only the bench scenarios can show the exact period length, the exact on-time as a product of prescale and duty, the saturation when duty reaches the scale, and the deferral of mid-period register changes. For this, the bench compares every tick of two whole periods against lengths it computes from the requirements.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int CTRL_W   = 8;
    localparam int EN_BIT   = 1;
    localparam int INV_BIT  = 0;

    typedef struct packed {
        logic en;
        logic pwm;
    } gen_state_t;
endpackage

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow #(
    parameter int PW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          bypass,
    input  logic [PW-1:0] raw_pre,
    input  logic [SW-1:0] raw_scl,
    input  logic [SW-1:0] raw_dut,
    output logic [PW-1:0] cur_pre,
    output logic [SW-1:0] cur_scl,
    output logic [SW-1:0] cur_dut,
    output logic [PW-1:0] shd_pre_o,
    output logic [SW-1:0] shd_scl_o
);
    typedef struct packed {
        logic [PW-1:0] pre;
        logic [SW-1:0] scl;
        logic [SW-1:0] dut;
    } shd_t;

    localparam logic [PW-1:0] PRE_ONE = PW'(1);

    shd_t          shd_q, shd_d;
    logic [PW-1:0] fix_pre;

    always_comb begin
        fix_pre = (raw_pre == '0) ? PRE_ONE : raw_pre;
        shd_d   = shd_q;
        if (load) begin
            shd_d.pre = fix_pre;
            shd_d.scl = raw_scl;
            shd_d.dut = raw_dut;
        end
        cur_pre = bypass ? fix_pre : shd_q.pre;
        cur_scl = bypass ? raw_scl : shd_q.scl;
        cur_dut = bypass ? raw_dut : shd_q.dut;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '{pre: PRE_ONE, scl: '0, dut: '0};
        end else begin
            shd_q <= shd_d;
        end
    end

    assign shd_pre_o = shd_q.pre;
    assign shd_scl_o = shd_q.scl;
endmodule

// File: rtl/bl_pwm_count.sv
module bl_pwm_count #(
    parameter int PW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          restart,
    input  logic [PW-1:0] pre_div,
    input  logic [SW-1:0] scale,
    input  logic [SW-1:0] duty,
    output logic          active,
    output logic          wrap,
    output logic [PW-1:0] pre_q_o,
    output logic [SW-1:0] step_q_o
);
    typedef struct packed {
        logic [PW-1:0] pre;
        logic [SW-1:0] step;
    } cnt_t;

    cnt_t          cnt_q, cnt_d;
    logic [PW-1:0] base_pre;
    logic [SW-1:0] base_step;
    logic          pre_last;

    always_comb begin
        base_pre  = restart ? '0 : cnt_q.pre;
        base_step = restart ? '0 : cnt_q.step;
        wrap      = (base_step == scale);
        pre_last  = (base_pre == pre_div - PW'(1));
        // position k = step*P + pre; active while k <= P*D
        active    = (duty >= scale) || (base_step < duty) ||
                    ((base_step == duty) && (base_pre == '0));
        cnt_d = cnt_q;
        if (adv) begin
            if (wrap) begin
                cnt_d.pre  = '0;
                cnt_d.step = '0;
            end else if (pre_last) begin
                cnt_d.pre  = '0;
                cnt_d.step = base_step + SW'(1);
            end else begin
                cnt_d.pre  = base_pre + PW'(1);
                cnt_d.step = base_step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pre_q_o  = cnt_q.pre;
    assign step_q_o = cnt_q.step;
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
    import bl_pwm_pkg::*;
#(
    parameter int PW = 8,
    parameter int SW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [PW-1:0]     cfg_prediv,
    input  logic [SW-1:0]     cfg_scale,
    input  logic [SW-1:0]     cfg_duty,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    output logic              pwm_o
);
    gen_state_t    st_q, st_d;
    logic          en_req, inv_req, start, run_tick, shd_load;
    logic          active, wrap;
    logic [PW-1:0] cur_pre, shd_pre, pre_q;
    logic [SW-1:0] cur_scl, cur_dut, shd_scl, step_q;
    logic          en_q;

    assign en_req   = cfg_ctrl[EN_BIT];
    assign inv_req  = cfg_ctrl[INV_BIT];
    assign start    = ref_tick && en_req && !st_q.en;
    assign run_tick = ref_tick && en_req;
    assign shd_load = run_tick && (start || wrap);
    assign en_q     = st_q.en;

    bl_pwm_shadow #(.PW(PW), .SW(SW)) i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shd_load),
        .bypass    (start),
        .raw_pre   (cfg_prediv),
        .raw_scl   (cfg_scale),
        .raw_dut   (cfg_duty),
        .cur_pre   (cur_pre),
        .cur_scl   (cur_scl),
        .cur_dut   (cur_dut),
        .shd_pre_o (shd_pre),
        .shd_scl_o (shd_scl)
    );

    bl_pwm_count #(.PW(PW), .SW(SW)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (run_tick),
        .restart  (start),
        .pre_div  (cur_pre),
        .scale    (cur_scl),
        .duty     (cur_dut),
        .active   (active),
        .wrap     (wrap),
        .pre_q_o  (pre_q),
        .step_q_o (step_q)
    );

    always_comb begin
        st_d = st_q;
        if (ref_tick) begin
            st_d.en  = en_req;
            st_d.pwm = en_req ? (active ^ inv_req) : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, pwm: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;
endmodule

// File: rtl/bl_pwm_gen_chk.sv
module bl_pwm_gen_chk #(
    parameter int PW = 8,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_tick,
    input logic [7:0]    cfg_ctrl,
    input logic          pwm_o,
    input logic          en_q,
    input logic [PW-1:0] pre_q,
    input logic [SW-1:0] step_q,
    input logic [PW-1:0] shd_pre,
    input logic [SW-1:0] shd_scl
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(ref_tick) |-> $stable(pwm_o)) else $error("hold"); // R8

    AST_OFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(ref_tick) && !$past(cfg_ctrl[1]) |-> pwm_o) else $error("off"); // R5

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(ref_tick) && $past(cfg_ctrl[1]) && !$past(en_q)
        |-> pwm_o == !$past(cfg_ctrl[0])) else $error("start"); // R7

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> pre_q < shd_pre) else $error("pre"); // R1

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> step_q <= shd_scl) else $error("step"); // R1

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> pwm_o && !en_q) else $error("rst"); // R9
endmodule

bind bl_pwm_gen bl_pwm_gen_chk #(.PW(PW), .SW(SW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .cfg_ctrl (cfg_ctrl),
    .pwm_o    (pwm_o),
    .en_q     (en_q),
    .pre_q    (pre_q),
    .step_q   (step_q),
    .shd_pre  (shd_pre),
    .shd_scl  (shd_scl)
);

// File: tb/test_bl_pwm_gen.sv
`timescale 1ns/1ps
module test_bl_pwm_gen;
    typedef struct packed {
        logic [7:0]  pre;
        logic [15:0] scl;
        logic [15:0] dut;
        logic        inv;
        logic [31:0] len;
        logic [31:0] on;
    } vec_t;

    // expected len = max(P,1)*S+1, on = min(max(P,1)*D, max(P,1)*S)+1
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 16'd4,  16'd2, 1'b0, 32'd5,  32'd3},   // R1 R2
        '{8'd3, 16'd4,  16'd1, 1'b0, 32'd13, 32'd4},   // R1 R2
        '{8'd2, 16'd5,  16'd5, 1'b0, 32'd11, 32'd11},  // R3
        '{8'd0, 16'd3,  16'd1, 1'b0, 32'd4,  32'd2},   // R4
        '{8'd4, 16'd3,  16'd0, 1'b1, 32'd13, 32'd1},   // R6
        '{8'd2, 16'd0,  16'd0, 1'b0, 32'd1,  32'd1},   // R1 zero scale
        '{8'd5, 16'd6,  16'd9, 1'b1, 32'd31, 32'd31},  // R3 R6
        '{8'd3, 16'd10, 16'd7, 1'b0, 32'd31, 32'd22}   // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [7:0]  cfg_prediv = '0;
    logic [15:0] cfg_scale = '0;
    logic [15:0] cfg_duty = '0;
    logic [7:0]  cfg_ctrl = '0;
    logic        pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bl_pwm_gen i_bl_pwm_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .cfg_prediv (cfg_prediv),
        .cfg_scale  (cfg_scale),
        .cfg_duty   (cfg_duty),
        .cfg_ctrl   (cfg_ctrl),
        .pwm_o      (pwm_o)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pwm_o=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R9 reset level", pwm_o, 1'b1);
        rst_n = 1'b1;
        idle(2);
        check("R9 after reset", pwm_o, 1'b1);

        // table walk: R1 R2 R3 R4 R6
        for (int v = 0; v < NV; v++) begin
            cfg_ctrl = 8'h00;
            tick();
            check("R5 off between vectors", pwm_o, 1'b1);
            cfg_prediv = VECS[v].pre;
            cfg_scale  = VECS[v].scl;
            cfg_duty   = VECS[v].dut;
            cfg_ctrl   = {6'b0, 1'b1, VECS[v].inv};
            for (int i = 0; i < 2 * int'(VECS[v].len); i++) begin
                tick();
                check($sformatf("R1/R2/R3 vec%0d pos%0d", v, i % int'(VECS[v].len)),
                      pwm_o ^ VECS[v].inv, (i % int'(VECS[v].len)) < int'(VECS[v].on));
            end
            tick();
            check($sformatf("R1 vec%0d next period starts active", v),
                  pwm_o ^ VECS[v].inv, 1'b1);
        end

        // R7: mid-period update deferred to the next period
        cfg_ctrl = 8'h00;
        tick();
        cfg_prediv = 8'd1; cfg_scale = 16'd4; cfg_duty = 16'd2;
        cfg_ctrl = 8'h02;
        tick(); check("R7 pos0 old", pwm_o, 1'b1);
        tick(); check("R7 pos1 old", pwm_o, 1'b1);
        cfg_scale = 16'd6; cfg_duty = 16'd1;
        tick(); check("R7 pos2 old", pwm_o, 1'b1);
        tick(); check("R7 pos3 old", pwm_o, 1'b0);
        tick(); check("R7 pos4 old", pwm_o, 1'b0);
        for (int i = 0; i < 7; i++) begin
            tick();
            check($sformatf("R7 new period pos%0d", i), pwm_o, i < 2);
        end

        // R5: disable mid-period, invert and upper bits ignored
        cfg_ctrl = 8'h03;
        tick(); tick(); tick();
        cfg_ctrl = 8'h01;
        tick(); check("R5 off with invert bit", pwm_o, 1'b1);
        cfg_ctrl = 8'hFD;
        tick(); check("R5 upper bits ignored", pwm_o, 1'b1);

        // R8: no change without a tick; R7 start uses current values
        cfg_ctrl = 8'h03;
        idle(5);
        check("R8 hold without tick", pwm_o, 1'b1);
        tick();
        check("R8/R7 start inverted active", pwm_o, 1'b0);
        idle(4);
        check("R8 hold after tick", pwm_o, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule